// File: doc/BRIEF.md
# Programmable Waveform Descriptor Sequencer

This block is a small interface engine. It moves 16-bit words between an internal endpoint FIFO and an external device. The engine does not follow fixed timing. It runs one of four stored waveform descriptors, and each descriptor holds seven programmable states, S0 to S6. A state is one of two kinds. A timed state holds the six control outputs at programmed levels for a programmed number of clocks. A decision state combines two selected condition inputs with a chosen logic operation and branches on the result. Any state can also ask for one FIFO word to be moved on its last cycle.

The engine has two states, ENG_IDLE and ENG_RUN. ENG_IDLE is the idle slot S7. ENG_RUN executes the current slot.
- The *launch* transition goes from ENG_IDLE to ENG_RUN on a start strobe and begins at S0.
- The *hold* transition stays in the same slot while a timed state's count runs.
- The *advance* transition moves to the next-state field when a timed state expires.
- The *branch* transition moves to the true target or the false target of a decision state.
- The *finish* transition returns to ENG_IDLE and pulses `done` for one cycle. It fires when the selected target is 7, or when the programmed transfer length is used up.

Descriptor entries are loaded through an address/data write port while the engine is idle.

Top module: `wavedesc_engine`

## Requirements
- R1: During and after reset, and whenever the engine is idle, `ctl` equals `idle_ctl`, `bus_oe` is low, `fifo_pop`/`fifo_push` are low and `done` is low (except for the finish pulse).
- R2: A `go` strobe while idle selects descriptor `go_sel`. In the next cycle the engine is running slot S0 of that descriptor, and `ctl` shows that entry's control field.
- R3: A timed entry (bit 31 = 0) drives its control field (bits 16:11) for N consecutive clocks. N is the hold field (bits 7:0), and a value of 0 means 256. The engine then proceeds to the slot in bits 30:28.
- R4: A decision entry (bit 31 = 1) lasts one clock. It picks operand A with bits 24:22 and operand B with bits 21:19. Select codes 0 to 5 pick `rdy[0..5]`, 6 picks `fifo_flag` and 7 picks `sw_rdy`. It combines them by bits 18:17: 0 = AND, 1 = OR, 2 = XOR, 3 = AND. A true result goes to bits 30:28, and a false result goes to bits 27:25.
- R5: An entry with bit 10 set produces exactly one FIFO move on its last cycle. That move is `fifo_pop` if the direction is 1 (out to the device) and `fifo_push` if it is 0. The two are never high together.
- R6: A target value of 7 ends the run. `done` is high for exactly one cycle, the first idle cycle after the final active cycle.
- R7: If `go_len` is nonzero, the run ends after the FIFO move that makes the `go_len`-th word, whatever the target. If `go_len` is 0, the length does not limit the run.
- R8: While running with direction 1, `bus_oe` is high and `bus_out` carries `fifo_rdata`. With direction 0, `bus_oe` is low and `fifo_wdata` carries `bus_in`.
- R9: Writes through `cfg_we` with address {descriptor, slot} store the entry when the engine is idle. Writes while running, and writes to slot 7, are ignored.
- R10: A `go` strobe while the engine is running has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor entry write strobe |
| cfg_addr | input | 5 | {descriptor[1:0], slot[2:0]} |
| cfg_wdata | input | 32 | Entry value |
| idle_ctl | input | 6 | Control levels while idle |
| go | input | 1 | Start strobe |
| go_sel | input | 2 | Descriptor to run |
| go_dir | input | 1 | 1: FIFO to device, 0: device to FIFO |
| go_len | input | 16 | Transfer length in words, 0 = unlimited |
| rdy | input | 6 | External ready inputs |
| fifo_flag | input | 1 | FIFO programmable flag |
| sw_rdy | input | 1 | Software ready bit |
| fifo_rdata | input | 16 | Word at FIFO head |
| fifo_pop | output | 1 | Advance FIFO read pointer |
| fifo_wdata | output | 16 | Word to store into FIFO |
| fifo_push | output | 1 | Advance FIFO write pointer |
| bus_in | input | 16 | Data bus from device |
| bus_out | output | 16 | Data bus to device |
| bus_oe | output | 1 | Data bus drive enable |
| ctl | output | 6 | Control outputs |
| done | output | 1 | Run finished pulse |

## Verification
Some properties are checked on every cycle:
- pop and push are never raised together.
- `done` is always a single-cycle pulse that follows an active cycle.
- A timed slot keeps its slot and control levels until its count expires.
- A `go` during a run leaves the selected descriptor and direction untouched.
- The descriptor store never changes while running.

Other behaviour can only be shown by the bench scenarios, which compare against a cycle-level reference model:
- the exact hold length, including 256 for a zero count
- branch targets under every operation and operand
- transfer-length termination
- that an ignored write leaves later runs unchanged

// File: rtl/wds_pkg.sv
package wds_pkg;
    localparam int ENTRY_W = 32;
    localparam int CTL_W   = 6;
    localparam logic [2:0] SLOT_END = 3'd7;

    typedef struct packed {
        logic             decide;
        logic [2:0]       tgt_a;
        logic [2:0]       tgt_b;
        logic [2:0]       sel_a;
        logic [2:0]       sel_b;
        logic [1:0]       op;
        logic [CTL_W-1:0] ctl;
        logic             adv;
        logic [1:0]       spare;
        logic [7:0]       hold;
    } entry_t;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_AND3 = 2'd3
    } op_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_t;
endpackage

// File: rtl/wds_store.sv
module wds_store
    import wds_pkg::*;
#(
    parameter int NDESC = 4,
    parameter int NSLOT = 7,
    localparam int SEL_W = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int ADDR_W = SEL_W + 3,
    localparam int NENT = NDESC * NSLOT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0]  wr_data,
    input  logic                lock,
    input  logic [SEL_W-1:0]    rd_desc,
    input  logic [2:0]          rd_slot,
    output entry_t              rd_entry
);
    logic [NENT-1:0][ENTRY_W-1:0] mem;
    logic [SEL_W-1:0] w_desc;
    logic [2:0]       w_slot;

    assign w_desc = wr_addr[ADDR_W-1:3];
    assign w_slot = wr_addr[2:0];

    for (genvar d = 0; d < NDESC; d++) begin : g_desc
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[d*NSLOT+s] <= '0;
                else if (wr_en && !lock && w_desc == SEL_W'(d) && w_slot == 3'(s))
                    mem[d*NSLOT+s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_entry = '0;
        if (int'(rd_slot) < NSLOT)
            rd_entry = entry_t'(mem[int'(rd_desc)*NSLOT + int'(rd_slot)]);
    end

    // R9: nothing in the store changes while the engine is running
    a_r9_store_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem));
endmodule

// File: rtl/wds_cond.sv
module wds_cond
    import wds_pkg::*;
(
    input  logic [7:0] pool,
    input  logic [2:0] sel_a,
    input  logic [2:0] sel_b,
    input  logic [1:0] op,
    output logic       hit
);
    logic opa, opb;

    assign opa = pool[sel_a];
    assign opb = pool[sel_b];

    always_comb begin
        unique case (op_t'(op))
            OP_OR:   hit = opa | opb;
            OP_XOR:  hit = opa ^ opb;
            default: hit = opa & opb;
        endcase
    end
endmodule

// File: rtl/wavedesc_engine.sv
module wavedesc_engine
    import wds_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NDESC  = 4,
    parameter int NSLOT  = 7,
    parameter int XFER_W = 16,
    localparam int SEL_W = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int ADDR_W = SEL_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic [CTL_W-1:0]   idle_ctl,
    input  logic               go,
    input  logic [SEL_W-1:0]   go_sel,
    input  logic               go_dir,
    input  logic [XFER_W-1:0]  go_len,
    input  logic [5:0]         rdy,
    input  logic               fifo_flag,
    input  logic               sw_rdy,
    input  logic [DATA_W-1:0]  fifo_rdata,
    output logic               fifo_pop,
    output logic [DATA_W-1:0]  fifo_wdata,
    output logic               fifo_push,
    input  logic [DATA_W-1:0]  bus_in,
    output logic [DATA_W-1:0]  bus_out,
    output logic               bus_oe,
    output logic [CTL_W-1:0]   ctl,
    output logic               done
);
    eng_t              st;
    logic [2:0]        slot;
    logic [SEL_W-1:0]  sel;
    logic              dir;
    logic [XFER_W-1:0] rem;
    logic [7:0]        ela;
    logic              done_q;

    entry_t     ent;
    logic       hit;
    logic       last;
    logic       adv;
    logic [2:0] tgt;
    logic       end_now;

    wds_store #(.NDESC(NDESC), .NSLOT(NSLOT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .lock     (st == ENG_RUN),
        .rd_desc  (sel),
        .rd_slot  (slot),
        .rd_entry (ent)
    );

    wds_cond u_cond (
        .pool  ({sw_rdy, fifo_flag, rdy}),
        .sel_a (ent.sel_a),
        .sel_b (ent.sel_b),
        .op    (ent.op),
        .hit   (hit)
    );

    // decode of the current entry
    always_comb begin
        last    = (st == ENG_RUN) && (ent.decide || ela == ent.hold - 8'd1);
        adv     = last && ent.adv;
        tgt     = (ent.decide && !hit) ? ent.tgt_b : ent.tgt_a;
        end_now = (tgt == SLOT_END) || (adv && rem == XFER_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ENG_IDLE;
            slot   <= '0;
            sel    <= '0;
            dir    <= 1'b0;
            rem    <= '0;
            ela    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    if (go) begin
                        st   <= ENG_RUN;
                        slot <= '0;
                        sel  <= go_sel;
                        dir  <= go_dir;
                        rem  <= go_len;
                        ela  <= '0;
                    end
                end
                ENG_RUN: begin
                    if (last) begin
                        if (adv && rem != '0)
                            rem <= rem - XFER_W'(1);
                        if (end_now) begin
                            st     <= ENG_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            slot <= tgt;
                            ela  <= '0;
                        end
                    end else begin
                        ela <= ela + 8'd1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ctl        = idle_ctl;
        bus_oe     = 1'b0;
        fifo_pop   = 1'b0;
        fifo_push  = 1'b0;
        unique case (st)
            ENG_RUN: begin
                ctl       = ent.ctl;
                bus_oe    = dir;
                fifo_pop  = adv && dir;
                fifo_push = adv && !dir;
            end
            default: ;
        endcase
        bus_out    = fifo_rdata;
        fifo_wdata = bus_in;
        done       = done_q;
    end

    // R5: a move is either a pop or a push, never both
    a_r5_one_move: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && fifo_push));

    // R6: done is a single pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only follows an active cycle
    a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st) == ENG_RUN);

    // R3: a timed slot keeps slot and levels until its count expires
    a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_RUN && !last) |=> (st == ENG_RUN && $stable(slot) && $stable(ctl)));

    // R1: bus not driven while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_IDLE) |-> (!bus_oe && !fifo_pop && !fifo_push));

    // R10: a strobe during a run leaves the selection alone
    a_r10_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ENG_RUN && go && !last) |=> ($stable(sel) && $stable(dir)));
endmodule

// File: tb/sim_wavedesc_engine.sv
`timescale 1ns/1ps
module sim_wavedesc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  idle_ctl = 6'h15;
    logic        go = 1'b0;
    logic [1:0]  go_sel = '0;
    logic        go_dir = 1'b0;
    logic [15:0] go_len = '0;
    logic [5:0]  rdy = '0;
    logic        fifo_flag = 1'b0;
    logic        sw_rdy = 1'b0;
    logic [15:0] fifo_rdata = '0;
    logic [15:0] bus_in = '0;
    logic        fifo_pop, fifo_push, bus_oe, done;
    logic [15:0] fifo_wdata, bus_out;
    logic [5:0]  ctl;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    wavedesc_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .idle_ctl(idle_ctl), .go(go), .go_sel(go_sel),
        .go_dir(go_dir), .go_len(go_len), .rdy(rdy), .fifo_flag(fifo_flag),
        .sw_rdy(sw_rdy), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
        .fifo_wdata(fifo_wdata), .fifo_push(fifo_push), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .ctl(ctl), .done(done)
    );

    // reference model state
    bit [31:0] bm [4][8];
    bit m_run = 0, m_dir = 0, m_done = 0;
    int m_slot = 0, m_sel = 0, m_rem = 0, m_ela = 0;
    int n_pop = 0, n_tag = 0;
    logic [5:0] tag_ctl = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cond_eval(bit [31:0] e);
        bit [7:0] pool = {sw_rdy, fifo_flag, rdy};
        bit a = pool[e[24:22]];
        bit b = pool[e[21:19]];
        case (e[18:17])
            2'd1:    return a | b;
            2'd2:    return a ^ b;
            default: return a & b;
        endcase
    endfunction

    // compare outputs with the model, then advance the model by one clock
    task automatic cycle(input bit we, input bit [4:0] addr, input bit [31:0] data,
                         input bit g, input bit [1:0] gs, input bit gd, input bit [15:0] gl);
        bit [31:0] e;
        int hl;
        bit last, adv, hit, fin;
        int tg;
        @(negedge clk);
        cfg_we = we; cfg_addr = addr; cfg_wdata = data;
        go = g; go_sel = gs; go_dir = gd; go_len = gl;
        rdy = 6'($urandom); fifo_flag = 1'($urandom); sw_rdy = 1'($urandom);
        fifo_rdata = 16'($urandom); bus_in = 16'($urandom);
        #1;
        e = bm[m_sel][m_slot];
        hl = (e[7:0] == 0) ? 256 : int'(e[7:0]);
        last = m_run && (e[31] || m_ela == hl - 1);
        adv = last && e[10];
        hit = cond_eval(e);
        if (m_run) begin
            chk("R2 R3 R4 ctl", ctl, e[16:11]);
            chk("R8 oe", bus_oe, m_dir);
        end else begin
            chk("R1 ctl", ctl, idle_ctl);
            chk("R1 oe", bus_oe, 0);
        end
        chk("R5 pop", fifo_pop, adv && m_dir);
        chk("R5 push", fifo_push, adv && !m_dir);
        chk("R6 R7 R10 done", done, m_done);
        if (m_dir && m_run) chk("R8 bus_out", bus_out, fifo_rdata);
        if (!m_dir) chk("R8 wdata", fifo_wdata, bus_in);
        if (fifo_pop || fifo_push) n_pop++;
        if (m_run && ctl == tag_ctl) n_tag++;
        // model update
        m_done = 0;
        if (!m_run) begin
            if (we && addr[2:0] != 3'd7) bm[addr[4:3]][addr[2:0]] = data;
            if (g) begin
                m_run = 1; m_slot = 0; m_sel = gs; m_dir = gd; m_rem = gl; m_ela = 0;
            end
        end else if (last) begin
            tg = (e[31] && !hit) ? int'(e[27:25]) : int'(e[30:28]);
            fin = (tg == 7) || (adv && m_rem == 1);
            if (adv && m_rem != 0) m_rem--;
            if (fin) begin m_run = 0; m_done = 1; m_slot = 0; end
            else begin m_slot = tg; m_ela = 0; end
        end else begin
            m_ela++;
        end
    endtask

    task automatic idle_cycle();
        cycle(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int d, input int s, input bit [31:0] v);
        cycle(1, 5'({2'(d), 3'(s)}), v, 0, 0, 0, 0);
    endtask

    task automatic run_to_end(input int lim);
        for (int i = 0; i < lim && (m_run || m_done); i++) idle_cycle();
    endtask

    function automatic bit [31:0] mk(bit dec, int ta, int tb, int sa, int sb, int op,
                                     int c, bit adv, int hold);
        return {dec, 3'(ta), 3'(tb), 3'(sa), 3'(sb), 2'(op), 6'(c), adv, 2'b00, 8'(hold)};
    endfunction

    function automatic bit [31:0] rnd_entry(int s);
        int ta = s + 1 + int'($urandom % (7 - s));
        int tb = s + 1 + int'($urandom % (7 - s));
        return mk(1'($urandom), ta, tb, int'($urandom % 8), int'($urandom % 8),
                  int'($urandom % 4), int'($urandom % 64), 1'($urandom),
                  1 + int'($urandom % 4));
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 8; s++) bm[d][s] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset ctl", ctl, idle_ctl);
        chk("R1 reset done", done, 0);
        chk("R1 reset oe", bus_oe, 0);
        rst_n = 1'b1;
        idle_cycle();

        // R3: zero hold count gives 256 clocks
        wr(3, 0, mk(0, 7, 0, 0, 0, 0, 6'h2A, 1, 0));
        tag_ctl = 6'h2A; n_tag = 0; n_pop = 0;
        cycle(0, 0, 0, 1, 2'd3, 1, 0);
        run_to_end(400);
        chk("R3 hold256 cycles", n_tag, 256);
        chk("R5 single pop", n_pop, 1);

        // R4: decision XOR of fifo_flag and sw_rdy
        wr(2, 0, mk(1, 1, 2, 6, 7, 2, 6'h01, 0, 1));
        wr(2, 1, mk(0, 7, 7, 0, 0, 0, 6'h11, 0, 1));
        wr(2, 2, mk(0, 7, 7, 0, 0, 0, 6'h22, 0, 1));
        for (int k = 0; k < 6; k++) begin
            cycle(0, 0, 0, 1, 2'd2, 0, 0);
            run_to_end(20);
        end

        // R7: self loop ends by transfer length; R9 write during run ignored
        wr(1, 0, mk(0, 0, 0, 0, 0, 0, 6'h33, 1, 2));
        n_pop = 0;
        cycle(0, 0, 0, 1, 2'd1, 0, 16'd5);
        cycle(1, 5'({2'd1, 3'd0}), mk(0, 7, 7, 0, 0, 0, 6'h05, 1, 1), 0, 0, 0, 0);
        cycle(0, 0, 0, 1, 2'd0, 1, 16'd1);   // R10 strobe while running
        run_to_end(100);
        chk("R7 five moves", n_pop, 5);
        n_pop = 0;
        cycle(0, 0, 0, 1, 2'd1, 1, 16'd3);
        run_to_end(100);
        chk("R9 entry kept after ignored write", n_pop, 3);
        wr(1, 7, 32'hFFFF_FFFF);             // R9 slot 7 ignored
        cycle(0, 0, 0, 1, 2'd1, 0, 16'd2);
        run_to_end(100);

        // random descriptors and starts
        for (int r = 0; r < 120; r++) begin
            if (r % 20 == 0) begin
                idle_ctl = 6'($urandom);
                for (int d = 0; d < 4; d++)
                    for (int s = 0; s < 7; s++) wr(d, s, rnd_entry(s));
            end
            cycle(0, 0, 0, 1, 2'($urandom), 1'($urandom), 16'($urandom % 4));
            for (int i = 0; i < 60 && (m_run || m_done); i++)
                cycle(1'($urandom), 5'($urandom), $urandom, 1'($urandom), 2'($urandom),
                      1'($urandom), 16'($urandom % 3));
            idle_cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R6 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule